// File: doc/BRIEF.md
# Timebase Counter with Reference-Match Interrupts

This block keeps a 64-bit timebase that advances by one on each count tick while counting is enabled. A debug freeze input can pause it when freezing is allowed. Two 32-bit reference channels each compare their value against the low 32-bit word of the timebase. When the count reaches a channel's value, that channel raises a sticky status flag. Software clears the flag by writing a one to its bit.

A 16-bit control and status word holds the count and freeze controls, the per-channel interrupt enables, the two flags and an 8-bit priority-level field. When a channel's flag and its enable are both set, the interrupt request goes out on every level output whose field bit is set. All access goes through a simple synchronous 16-bit register bus. Reads are registered and always enabled. The timebase can only be written while counting is off.

Top module: `tbase_cmp_unit`

## Requirements
- R1: After a cycle with `rst` high, every control and status bit is 0, the timebase is 0, both reference values are 0, `rd_data_o` is 0 and `irq_lvl_o` is 0.
- R2: The control word at address 0 has this layout: bits 15:8 are the level field, bit 7 is flag A, bit 6 is flag B, bit 3 is enable A, bit 2 is enable B, bit 1 is freeze-allow and bit 0 is count-enable. Bits 5:4 read 0, and writes to them are ignored.
- R3: The timebase advances by 1, carrying across all 64 bits, on each clock edge where `tick_i`=1 and count-enable=1, unless freeze-allow=1 and `freeze_i`=1. Otherwise it holds.
- R4: The timebase words sit at addresses 5 (bits 63:48), 6, 7 and 8 (bits 15:0). A write to them takes effect only while count-enable is 0 at that edge; otherwise it is ignored.
- R5: Reference A sits at address 1 (bits 31:16) and address 2 (bits 15:0). Reference B sits at address 3 (bits 31:16) and address 4 (bits 15:0). Each half is written and read on its own.
- R6: A channel's flag sets on the edge where the timebase advances and its new low word equals that channel's reference. The flag then stays set.
- R7: Writing a 1 to bit 7 or bit 6 of the control word clears flag A or flag B; writing 0 leaves it unchanged. One write can clear both. If a set and a clear fall on the same edge, the flag ends up set.
- R8: The pending condition is (flag A and enable A) or (flag B and enable B). One cycle after the register state, `irq_lvl_o[k]` equals pending AND control bit (15-k).
- R9: `rd_data_o` shows, one cycle later, the register at the address presented. A write in that same cycle is not yet visible in it.
- R10: Addresses 9 to 15 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count tick, one advance per high cycle |
| freeze_i | input | 1 | Debug freeze request |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Registered read data |
| irq_lvl_o | output | 8 | Interrupt request per priority level |

## Verification
Each result has a fixed latency:
- The timebase and the flags change on the same edge as the tick or write that moves them.
- `rd_data_o` shows the register at the address presented, one edge later.
- `irq_lvl_o` follows a flag or enable change one edge after that change.

The bench drives inputs on the falling edge. A behavioural model, updated on the rising edge, uses these same latencies. Both outputs are compared against it at the next falling edge. Directed checks read back in the cycle after each event, so a flag is seen one read later and a level change one cycle after the flag.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int CSR_W   = 16;
  localparam int LVL_N   = 8;
  localparam int LVL_LSB = 8;
  // bit positions inside the control word
  localparam int B_STA_A = 7;
  localparam int B_STA_B = 6;
  localparam int B_EN_A  = 3;
  localparam int B_EN_B  = 2;
  localparam int B_FRZ   = 1;
  localparam int B_CNT   = 0;
  localparam int NCH     = 2;

  typedef struct packed {
    logic [LVL_N-1:0] lvl;
    logic             en_a;
    logic             en_b;
    logic             frz_en;
    logic             cnt_en;
  } tbc_ctrl_t;

  function automatic logic [CSR_W-1:0] pack_csr(input tbc_ctrl_t c,
                                                input logic fa, input logic fb);
    logic [CSR_W-1:0] w;
    w = '0;
    w[LVL_LSB +: LVL_N] = c.lvl;
    w[B_STA_A] = fa;
    w[B_STA_B] = fb;
    w[B_EN_A]  = c.en_a;
    w[B_EN_B]  = c.en_b;
    w[B_FRZ]   = c.frz_en;
    w[B_CNT]   = c.cnt_en;
    return w;
  endfunction

  function automatic tbc_ctrl_t unpack_ctrl(input logic [CSR_W-1:0] w);
    tbc_ctrl_t c;
    c.lvl    = w[LVL_LSB +: LVL_N];
    c.en_a   = w[B_EN_A];
    c.en_b   = w[B_EN_B];
    c.frz_en = w[B_FRZ];
    c.cnt_en = w[B_CNT];
    return c;
  endfunction
endpackage

// File: rtl/tbc_counter.sv
module tbc_counter #(
  parameter int TB_W  = 64,
  parameter int DW    = 16,
  parameter int CMP_W = 32,
  localparam int NW   = TB_W / DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic [NW-1:0]    wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [TB_W-1:0]  tb_o,
  output logic [CMP_W-1:0] nxt_lo_o
);
  logic [TB_W-1:0] tb_q;
  logic [TB_W-1:0] tb_inc;

  assign tb_inc   = tb_q + TB_W'(1);
  assign nxt_lo_o = tb_inc[CMP_W-1:0];
  assign tb_o     = tb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tb_q <= '0;
    end else if (adv_i) begin
      tb_q <= tb_inc;
    end else begin
      for (int w = 0; w < NW; w++) begin
        if (wr_sel_i[w]) tb_q[w*DW +: DW] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/tbc_ref_chan.sv
module tbc_ref_chan #(
  parameter int RW  = 32,
  parameter int DW  = 16,
  localparam int NH = RW / DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NH-1:0] wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          adv_i,
  input  logic [RW-1:0] cand_i,
  input  logic          clr_i,
  output logic          flag_o,
  output logic [RW-1:0] ref_o
);
  logic [RW-1:0] ref_q;
  logic          flag_q;
  logic          hit;

  assign hit    = adv_i && (cand_i == ref_q);
  assign flag_o = flag_q;
  assign ref_o  = ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
    end else begin
      for (int h = 0; h < NH; h++) begin
        if (wr_sel_i[h]) ref_q[h*DW +: DW] <= wr_data_i;
      end
    end
  end

  // a new match outranks a clearing write
  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= hit | (flag_q & ~clr_i);
  end
endmodule

// File: rtl/tbc_irq_steer.sv
module tbc_irq_steer #(
  parameter int NCH   = 2,
  parameter int LVL_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   flags_i,
  input  logic [NCH-1:0]   ens_i,
  input  logic [LVL_N-1:0] lvl_i,
  output logic [LVL_N-1:0] irq_o
);
  logic             pend;
  logic [LVL_N-1:0] lvl_rev;

  assign pend = |(flags_i & ens_i);

  generate
    for (genvar k = 0; k < LVL_N; k++) begin : g_rev
      assign lvl_rev[k] = lvl_i[LVL_N-1-k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= lvl_rev & {LVL_N{pend}};
  end
endmodule

// File: rtl/tbase_cmp_unit.sv
module tbase_cmp_unit
  import tbc_pkg::*;
#(
  parameter int TB_W  = 64,
  parameter int REF_W = 32,
  parameter int DW    = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             freeze_i,
  input  logic             bus_wr_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [LVL_N-1:0] irq_lvl_o
);
  localparam int TB_NW  = TB_W / DW;
  localparam int REF_NH = REF_W / DW;
  localparam int A_CSR  = 0;
  localparam int A_REF  = 1;
  localparam int A_TB   = A_REF + NCH * REF_NH;

  tbc_ctrl_t          ctrl_q;
  logic               cnt_en, frz_en, en_a, en_b;
  logic               wr_csr, adv;
  logic [TB_NW-1:0]   sel_tb;
  logic [REF_NH-1:0]  sel_ref [NCH];
  logic [NCH-1:0]     flags, ens;
  logic [REF_W-1:0]   ref_val [NCH];
  logic [TB_W-1:0]    tb_q;
  logic [REF_W-1:0]   tb_nxt_lo;
  logic               flag_a, flag_b;
  logic [DW-1:0]      rd_nxt;

  assign cnt_en = ctrl_q.cnt_en;
  assign frz_en = ctrl_q.frz_en;
  assign en_a   = ctrl_q.en_a;
  assign en_b   = ctrl_q.en_b;
  assign ens    = {en_b, en_a};
  assign flag_a = flags[0];
  assign flag_b = flags[1];

  assign wr_csr = bus_wr_i && (bus_addr_i == AW'(A_CSR));
  assign adv    = tick_i && cnt_en && !(frz_en && freeze_i);

  generate
    for (genvar w = 0; w < TB_NW; w++) begin : g_tbsel
      assign sel_tb[w] = bus_wr_i && !cnt_en &&
                         (bus_addr_i == AW'(A_TB + TB_NW - 1 - w));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '0;
    else if (wr_csr) ctrl_q <= unpack_ctrl(bus_wdata_i);
  end

  tbc_counter #(.TB_W(TB_W), .DW(DW), .CMP_W(REF_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .adv_i    (adv),
    .wr_sel_i (sel_tb),
    .wr_data_i(bus_wdata_i),
    .tb_o     (tb_q),
    .nxt_lo_o (tb_nxt_lo)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      for (genvar h = 0; h < REF_NH; h++) begin : g_sel
        assign sel_ref[c][h] = bus_wr_i &&
               (bus_addr_i == AW'(A_REF + c*REF_NH + REF_NH - 1 - h));
      end
      tbc_ref_chan #(.RW(REF_W), .DW(DW)) u_ch (
        .clk      (clk),
        .rst      (rst),
        .wr_sel_i (sel_ref[c]),
        .wr_data_i(bus_wdata_i),
        .adv_i    (adv),
        .cand_i   (tb_nxt_lo),
        .clr_i    (wr_csr && bus_wdata_i[B_STA_A - c]),
        .flag_o   (flags[c]),
        .ref_o    (ref_val[c])
      );
    end
  endgenerate

  tbc_irq_steer #(.NCH(NCH), .LVL_N(LVL_N)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .flags_i(flags),
    .ens_i  (ens),
    .lvl_i  (ctrl_q.lvl),
    .irq_o  (irq_lvl_o)
  );

  always_comb begin
    rd_nxt = '0;
    if (bus_addr_i == AW'(A_CSR)) rd_nxt = pack_csr(ctrl_q, flag_a, flag_b);
    for (int c = 0; c < NCH; c++) begin
      for (int h = 0; h < REF_NH; h++) begin
        if (bus_addr_i == AW'(A_REF + c*REF_NH + REF_NH - 1 - h))
          rd_nxt = ref_val[c][h*DW +: DW];
      end
    end
    for (int w = 0; w < TB_NW; w++) begin
      if (bus_addr_i == AW'(A_TB + TB_NW - 1 - w)) rd_nxt = tb_q[w*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_nxt;
  end
endmodule

// File: rtl/tbc_chk.sv
module tbc_chk #(
  parameter int TB_W  = 64,
  parameter int DW    = 16,
  parameter int AW    = 4,
  parameter int LVL_N = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_i,
  input logic             freeze_i,
  input logic             bus_wr_i,
  input logic [AW-1:0]    bus_addr_i,
  input logic [DW-1:0]    bus_wdata_i,
  input logic [DW-1:0]    rd_data_o,
  input logic [LVL_N-1:0] irq_lvl_o,
  input logic [TB_W-1:0]  tb_q,
  input logic             flag_a,
  input logic             flag_b,
  input logic             cnt_en,
  input logic             frz_en,
  input logic             en_a,
  input logic             en_b
);
  logic moving;
  logic csr_wr;
  assign moving = tick_i && cnt_en && !(frz_en && freeze_i);
  assign csr_wr = bus_wr_i && (bus_addr_i == '0);

  // R1
  rst_state_chk: assert property (@(posedge clk)
    rst |=> (rd_data_o == '0 && irq_lvl_o == '0 && tb_q == '0 && !flag_a && !flag_b));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_i == '0) |=> (rd_data_o[5:4] == 2'b00));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    moving |=> (tb_q == $past(tb_q) + TB_W'(1)));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !moving) |=> $stable(tb_q));

  // R4
  tb_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !bus_wr_i) |=> $stable(tb_q));

  // R6
  flag_a_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_a && !(csr_wr && bus_wdata_i[tbc_pkg::B_STA_A])) |=> flag_a);

  // R7
  flag_b_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && bus_wdata_i[tbc_pkg::B_STA_B] && !moving) |=> !flag_b);

  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !((flag_a && en_a) || (flag_b && en_b)) |=> (irq_lvl_o == '0));
endmodule

bind tbase_cmp_unit tbc_chk #(.TB_W(TB_W), .DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_i     (tick_i),
  .freeze_i   (freeze_i),
  .bus_wr_i   (bus_wr_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .rd_data_o  (rd_data_o),
  .irq_lvl_o  (irq_lvl_o),
  .tb_q       (tb_q),
  .flag_a     (flag_a),
  .flag_b     (flag_b),
  .cnt_en     (cnt_en),
  .frz_en     (frz_en),
  .en_a       (en_a),
  .en_b       (en_b)
);

// File: tb/tbase_cmp_unit_tb.sv
`timescale 1ns/1ps
module tbase_cmp_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, frz = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wd = '0;
  logic [15:0] rd;
  logic [7:0]  irq;

  int nvec = 0;
  int nerr = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tbase_cmp_unit u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .freeze_i(frz), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wd), .rd_data_o(rd), .irq_lvl_o(irq)
  );

  // behavioural reference state
  bit [63:0] m_tb;
  bit [31:0] m_ra, m_rb;
  bit [7:0]  m_lvl;
  bit        m_fa, m_fb, m_ea, m_eb, m_tf, m_te;
  bit [15:0] m_rd;
  bit [7:0]  m_irq;

  function automatic bit [15:0] m_read(input bit [3:0] a);
    case (a)
      4'd0: return {m_lvl, m_fa, m_fb, 2'b00, m_ea, m_eb, m_tf, m_te};
      4'd1: return m_ra[31:16];
      4'd2: return m_ra[15:0];
      4'd3: return m_rb[31:16];
      4'd4: return m_rb[15:0];
      4'd5: return m_tb[63:48];
      4'd6: return m_tb[47:32];
      4'd7: return m_tb[31:16];
      4'd8: return m_tb[15:0];
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(input bit [3:0] a);
    if (a == 0) return "R2 control read";
    if (a <= 4) return "R5 reference read";
    if (a <= 8) return "R3 timebase read";
    return "R10 unmapped read";
  endfunction

  always @(posedge clk) begin : model
    bit adv, sa, sb, ca, cb, pend;
    bit [63:0] nx;
    if (rst) begin
      m_tb = 0; m_ra = 0; m_rb = 0; m_lvl = 0;
      m_fa = 0; m_fb = 0; m_ea = 0; m_eb = 0; m_tf = 0; m_te = 0;
      m_rd = 0; m_irq = 0;
    end else begin
      m_rd = m_read(addr);
      pend = (m_fa & m_ea) | (m_fb & m_eb);
      for (int k = 0; k < 8; k++) m_irq[k] = pend & m_lvl[7-k];
      adv = tick && m_te && !(m_tf && frz);
      nx  = m_tb + 64'd1;
      sa  = adv && (nx[31:0] == m_ra);
      sb  = adv && (nx[31:0] == m_rb);
      ca  = wr && addr == 0 && wd[7];
      cb  = wr && addr == 0 && wd[6];
      m_fa = sa | (m_fa & !ca);
      m_fb = sb | (m_fb & !cb);
      if (adv) m_tb = nx;
      else if (wr && !m_te) begin
        case (addr)
          4'd5: m_tb[63:48] = wd;
          4'd6: m_tb[47:32] = wd;
          4'd7: m_tb[31:16] = wd;
          4'd8: m_tb[15:0]  = wd;
          default: ;
        endcase
      end
      if (wr) begin
        case (addr)
          4'd0: begin
            m_lvl = wd[15:8]; m_ea = wd[3]; m_eb = wd[2]; m_tf = wd[1]; m_te = wd[0];
          end
          4'd1: m_ra[31:16] = wd;
          4'd2: m_ra[15:0]  = wd;
          4'd3: m_rb[31:16] = wd;
          4'd4: m_rb[15:0]  = wd;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at the falling edge, compare at the next falling edge
  task automatic cyc(input bit w, input bit [3:0] a, input bit [15:0] d,
                     input bit t, input bit f);
    wr = w; addr = a; wd = d; tick = t; frz = f;
    @(posedge clk);
    @(negedge clk);
    check(tag_of(a), rd, m_rd);
    check("R8 level outputs", irq, m_irq);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      nerr++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cyc(0, 0, 0, 0, 0);  check("R1 control after reset", rd, 16'h0000);
    cyc(0, 8, 0, 0, 0);  check("R1 timebase after reset", rd, 16'h0000);
    check("R1 levels after reset", irq, 8'h00);
    // R5 references
    cyc(1, 1, 16'h0000, 0, 0); cyc(1, 2, 16'h0005, 0, 0);
    cyc(1, 3, 16'h0000, 0, 0); cyc(1, 4, 16'h0008, 0, 0);
    cyc(0, 2, 0, 0, 0);  check("R5 ref A low half", rd, 16'h0005);
    // R9 read in the same cycle as a write returns the old value
    cyc(1, 4, 16'h0009, 0, 0); check("R9 read during write", rd, 16'h0008);
    cyc(0, 4, 0, 0, 0);  check("R9 read after write", rd, 16'h0009);
    // load timebase while stopped, then enable A, freeze-allow, count
    cyc(1, 8, 16'h0002, 0, 0);
    cyc(1, 0, 16'h200B, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);  check("R6 flag A at match", rd, 16'h208B);
    check("R8 level 2 raised", irq, 8'h04);
    // R4 write ignored while counting is enabled
    cyc(1, 8, 16'h1234, 0, 0);
    cyc(0, 8, 0, 0, 0);  check("R4 locked write", rd, 16'h0005);
    // R3 freeze holds the count
    cyc(0, 8, 0, 1, 1); cyc(0, 8, 0, 1, 1);
    cyc(0, 8, 0, 0, 0);  check("R3 frozen", rd, 16'h0005);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0);
    check("R8 disabled channel B adds nothing", irq, 8'h04);
    // R7 write-0 keeps, write-1 clears both
    cyc(1, 0, 16'h200B, 0, 0);
    cyc(0, 0, 0, 0, 0);  check("R7 zero write keeps flags", rd, 16'h20CB);
    cyc(1, 0, 16'h20CB, 0, 0);
    cyc(0, 0, 0, 0, 0);  check("R7 both flags cleared", rd, 16'h200B);
    check("R8 level dropped", irq, 8'h00);
    // R7 set and clear on the same edge: set wins
    cyc(1, 4, 16'h000B, 0, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(1, 0, 16'h204B, 1, 0);
    cyc(0, 0, 0, 0, 0);  check("R7 set beats clear", rd, 16'h204B);
    // R3 carry into the upper word
    cyc(1, 0, 16'h0000, 0, 0);
    cyc(1, 5, 16'h0000, 0, 0); cyc(1, 6, 16'h0001, 0, 0);
    cyc(1, 7, 16'hFFFF, 0, 0); cyc(1, 8, 16'hFFFE, 0, 0);
    cyc(1, 0, 16'h0001, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 8, 0, 1, 0);
    cyc(0, 6, 0, 0, 0);  check("R3 carry word 47:32", rd, 16'h0002);
    cyc(0, 7, 0, 0, 0);  check("R3 carry word 31:16", rd, 16'h0000);
    cyc(0, 8, 0, 0, 0);  check("R3 carry word 15:0", rd, 16'h0001);
    // R10 unmapped, R2 reserved bits
    cyc(1, 12, 16'hFFFF, 0, 0);
    cyc(0, 12, 0, 0, 0); check("R10 unmapped reads zero", rd, 16'h0000);
    cyc(1, 0, 16'h0031, 0, 0);
    cyc(0, 0, 0, 0, 0);  check("R2 reserved bits ignored", rd, 16'h0041);
    // R8 several levels at once through channel B
    cyc(1, 0, 16'h8104, 0, 0);
    cyc(0, 0, 0, 0, 0);  check("R8 levels 0 and 7", irq, 8'h81);
    // R1 reset in mid-run
    rst = 1'b1;
    cyc(0, 0, 0, 0, 0);
    rst = 1'b0;
    cyc(0, 0, 0, 0, 0);  check("R1 control after second reset", rd, 16'h0000);
    check("R1 levels after second reset", irq, 8'h00);
    cyc(0, 3, 0, 0, 0);  check("R1 reference cleared", rd, 16'h0000);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule